// File: doc/BRIEF.md
# Six-Channel Event-Action PWM Generator

This block produces six pulse-width-modulated outputs from one shared timebase. A prescaler divides the system clock into counter ticks. A 16-bit counter runs in up, down or up-down mode against a shared period value. Each channel compares the counter against its own 16-bit compare value. The timebase produces four kinds of event: the counter at zero, the counter at the period value, a compare match on the rising leg and a compare match on the falling leg. For each event, every channel holds a programmable action that leaves its waveform alone, drives it low, drives it high or toggles it.

Software writes period and compare values into shadow registers. The shadow values move into the working registers at the end of a counter cycle. Two options change this: an immediate-load option that applies a write at once, and a center-load option that also reloads at the turning point of an up-down cycle. After the action logic, each output can be forced to a fixed level by a mask and then inverted by a polarity bit. The block also drives one-cycle pulses for every event, so that interrupt logic or a testbench can follow the timebase.

Top module: `evpwm_top`

## Requirements
- R1: After a synchronous reset, all outputs are 0, the counter is 0, all configuration registers are 0 and no event pulse is asserted.
- R2: The prescaler value written at address 0 (bits 11:0) makes the counter move once every prescale+1 clocks while `run` is high.
- R3: Mode 0 (up), chosen in bits 1:0 of address 2, counts 0,1,...,P and then returns to 0. The zero event fires on the tick at count 0 and the period event fires on the tick at count P.
- R4: Mode 1 (down) counts P down to 0 and then reloads P. A compare match in this mode is a falling-leg match.
- R5: Mode 2 (up-down) counts 0 up to P and back down to 0. A compare match raises the rising-leg event while the counter climbs and the falling-leg event while it descends. The first pass through 0 after a reset or a clear counts as climbing.
- R6: While `run` is low, or while the working period is 0, the counter and the prescaler hold and no event fires.
- R7: Writes to the period (address 1) and to the compares (addresses 8+n) go to shadow registers. These are copied to the working registers at the end of a cycle: count P in up mode, count 0 in down and up-down modes. The copy also happens on any cycle in which the working period is 0.
- R8: With the immediate bit (address 2, bit 2) set, a period or compare write updates the working register on the same edge.
- R9: With the center bit (address 2, bit 3) set in up-down mode, the shadows are also copied at the period turning point.
- R10: Each channel's action byte at address 16+n holds four 2-bit codes: bits 1:0 zero, bits 3:2 rising compare, bits 5:4 period, bits 7:6 falling compare. The codes are 0 for no change, 1 for low, 2 for high and 3 for toggle.
- R11: When several events hit a channel on one tick, the first non-zero action in the order falling compare, rising compare, period, zero is applied.
- R12: The output is the mask level (address 5) where the mask enable (address 4) is set, otherwise the waveform. The result is XORed with the polarity bit (address 6) and registered.
- R13: A write to address 3 sets the counter to 0, or to the working period in down mode, restarts the prescaler and resets the direction to climbing. The shadow and working registers are not changed.
- R14: Event pulses last one clock and come one clock after the tick that caused them, on the same edge as the output change that the event caused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable (start/stop) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | NCH | Registered channel outputs |
| cnt_o | output | 16 | Current counter value |
| ev_zero | output | 1 | Zero event pulse |
| ev_prd | output | 1 | Period event pulse |
| ev_cmpu | output | NCH | Rising-leg compare pulse per channel |
| ev_cmpd | output | NCH | Falling-leg compare pulse per channel |

## Verification
The assertions check on every cycle the properties that span the timebase and channel logic. A rising and a falling compare pulse never fire together on one channel. Zero and period pulses only follow the matching count. A stopped counter holds its value. A clear lands on the mode's start value, and no pulse fires while the block is stopped. Only the bench's scenarios can show the waveforms themselves. These include when shadow values take effect under the three load policies, how priority resolves when events coincide, how mask and polarity combine, and the sequence of counts in each mode. The bench compares them cycle by cycle against its own model of the requirements.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;
  localparam int ADDR_W = 5;

  localparam logic [1:0] MD_UP   = 2'd0;
  localparam logic [1:0] MD_DOWN = 2'd1;
  localparam logic [1:0] MD_UPDN = 2'd2;

  localparam logic [1:0] ACT_KEEP = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_HIGH = 2'd2;
  localparam logic [1:0] ACT_TOG  = 2'd3;

  localparam int A_PSC = 0;
  localparam int A_PER = 1;
  localparam int A_CTL = 2;
  localparam int A_CLR = 3;
  localparam int A_MEN = 4;
  localparam int A_MLV = 5;
  localparam int A_POL = 6;
  localparam int A_CMP = 8;
  localparam int A_ACT = 16;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (code)
      ACT_LOW:  apply_act = 1'b0;
      ACT_HIGH: apply_act = 1'b1;
      ACT_TOG:  apply_act = ~cur;
      default:  apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
  import evpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PW  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     ld_end,
  input  logic                     ld_mid,
  output logic [PW-1:0]            psc,
  output logic [CW-1:0]            per_sh,
  output logic [CW-1:0]            per_act,
  output logic [NCH-1:0][CW-1:0]   cmp_act,
  output logic [NCH-1:0][7:0]      act_tbl,
  output logic [1:0]               mode,
  output logic [NCH-1:0]           men,
  output logic [NCH-1:0]           mlvl,
  output logic [NCH-1:0]           pol,
  output logic                     clr_stb
);
  localparam logic [ADDR_W-1:0] AD_PSC = ADDR_W'(A_PSC);
  localparam logic [ADDR_W-1:0] AD_PER = ADDR_W'(A_PER);
  localparam logic [ADDR_W-1:0] AD_CTL = ADDR_W'(A_CTL);
  localparam logic [ADDR_W-1:0] AD_CLR = ADDR_W'(A_CLR);
  localparam logic [ADDR_W-1:0] AD_MEN = ADDR_W'(A_MEN);
  localparam logic [ADDR_W-1:0] AD_MLV = ADDR_W'(A_MLV);
  localparam logic [ADDR_W-1:0] AD_POL = ADDR_W'(A_POL);

  logic imm_en;
  logic mid_en;
  logic reload;

  assign clr_stb = wr_en && (wr_addr == AD_CLR);
  assign reload  = ld_end || (ld_mid && mid_en) || (per_act == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc    <= '0;
      per_sh <= '0;
      mode   <= MD_UP;
      imm_en <= 1'b0;
      mid_en <= 1'b0;
      men    <= '0;
      mlvl   <= '0;
      pol    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AD_PSC: psc <= wr_data[PW-1:0];
        AD_PER: per_sh <= wr_data;
        AD_CTL: begin
          mode   <= wr_data[1:0];
          imm_en <= wr_data[2];
          mid_en <= wr_data[3];
        end
        AD_MEN: men  <= wr_data[NCH-1:0];
        AD_MLV: mlvl <= wr_data[NCH-1:0];
        AD_POL: pol  <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_act <= '0;
    end else if (wr_en && (wr_addr == AD_PER) && imm_en) begin
      per_act <= wr_data;
    end else if (reload) begin
      per_act <= per_sh;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] AD_C = ADDR_W'(A_CMP + g);
    localparam logic [ADDR_W-1:0] AD_A = ADDR_W'(A_ACT + g);
    logic [CW-1:0] cmp_sh;
    logic          hit_c;

    assign hit_c = wr_en && (wr_addr == AD_C);

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_sh     <= '0;
        cmp_act[g] <= '0;
        act_tbl[g] <= '0;
      end else begin
        if (hit_c) cmp_sh <= wr_data;
        if (hit_c && imm_en) cmp_act[g] <= wr_data;
        else if (reload)     cmp_act[g] <= cmp_sh;
        if (wr_en && (wr_addr == AD_A)) act_tbl[g] <= wr_data[7:0];
      end
    end
  end
endmodule

// File: rtl/evpwm_timebase.sv
module evpwm_timebase
  import evpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] psc,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] per_sh,
  output logic [CW-1:0] cnt,
  output logic          dn,
  output logic          tick,
  output logic          at_zero,
  output logic          at_prd,
  output logic          ld_end,
  output logic          ld_mid
);
  logic [PW-1:0] pcnt;
  logic          live;
  logic          top_hit;

  assign live    = run && (per_act != '0);
  assign tick    = live && (pcnt >= psc);
  assign top_hit = cnt >= per_act;
  assign at_zero = tick && (cnt == '0);
  assign at_prd  = tick && (cnt == per_act);
  assign ld_end  = tick && ((mode == MD_DOWN || mode == MD_UPDN) ? (cnt == '0) : top_hit);
  assign ld_mid  = tick && (mode == MD_UPDN) && top_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      cnt  <= '0;
      dn   <= 1'b0;
    end else if (clr) begin
      pcnt <= '0;
      cnt  <= (mode == MD_DOWN) ? per_act : '0;
      dn   <= 1'b0;
    end else if (live) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) begin
        case (mode)
          MD_DOWN: cnt <= (cnt == '0) ? per_sh : cnt - 1'b1;
          MD_UPDN: begin
            if (top_hit) begin
              cnt <= per_act - 1'b1;
              dn  <= 1'b1;
            end else if (cnt == '0) begin
              cnt <= {{(CW-1){1'b0}}, 1'b1};
              dn  <= 1'b0;
            end else begin
              cnt <= dn ? cnt - 1'b1 : cnt + 1'b1;
            end
          end
          default: cnt <= top_hit ? '0 : cnt + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/evpwm_chan.sv
module evpwm_chan
  import evpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          dn,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] cmp,
  input  logic [7:0]    acts,
  input  logic          at_zero,
  input  logic          at_prd,
  input  logic          men,
  input  logic          mlvl,
  input  logic          pol,
  output logic          pin,
  output logic          ev_cu,
  output logic          ev_cd
);
  logic       match;
  logic       fall_leg;
  logic       cu;
  logic       cd;
  logic [1:0] sel;
  logic       wav;
  logic       wav_n;

  assign match    = tick && (cnt == cmp);
  assign fall_leg = (mode == MD_DOWN) || ((mode == MD_UPDN) && dn);
  assign cu       = match && !fall_leg;
  assign cd       = match && fall_leg;

  always_comb begin
    sel = ACT_KEEP;
    if (cd && acts[7:6] != ACT_KEEP)           sel = acts[7:6];
    else if (cu && acts[3:2] != ACT_KEEP)      sel = acts[3:2];
    else if (at_prd && acts[5:4] != ACT_KEEP)  sel = acts[5:4];
    else if (at_zero && acts[1:0] != ACT_KEEP) sel = acts[1:0];
  end

  assign wav_n = apply_act(sel, wav);

  always_ff @(posedge clk) begin
    if (rst) begin
      wav   <= 1'b0;
      pin   <= 1'b0;
      ev_cu <= 1'b0;
      ev_cd <= 1'b0;
    end else begin
      wav   <= wav_n;
      pin   <= (men ? mlvl : wav_n) ^ pol;
      ev_cu <= cu;
      ev_cd <= cd;
    end
  end
endmodule

// File: rtl/evpwm_top.sv
module evpwm_top
  import evpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [NCH-1:0]    pwm_out,
  output logic [CW-1:0]     cnt_o,
  output logic              ev_zero,
  output logic              ev_prd,
  output logic [NCH-1:0]    ev_cmpu,
  output logic [NCH-1:0]    ev_cmpd
);
  localparam int MAX_CH = A_ACT - A_CMP;

  logic [PW-1:0]          psc;
  logic [CW-1:0]          per_sh;
  logic [CW-1:0]          per_act;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [NCH-1:0][7:0]    act_tbl;
  logic [1:0]             mode;
  logic [NCH-1:0]         men, mlvl, pol;
  logic                   clr_stb;
  logic                   tick, dn, at_zero, at_prd, ld_end, ld_mid;

  initial begin
    if (NCH > MAX_CH || NCH > CW) $error("evpwm_top: NCH too large for address map");
  end

  evpwm_regs #(.NCH(NCH), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_end(ld_end), .ld_mid(ld_mid), .psc(psc), .per_sh(per_sh),
    .per_act(per_act), .cmp_act(cmp_act), .act_tbl(act_tbl), .mode(mode),
    .men(men), .mlvl(mlvl), .pol(pol), .clr_stb(clr_stb)
  );

  evpwm_timebase #(.CW(CW), .PW(PW)) u_tb (
    .clk(clk), .rst(rst), .run(run), .clr(clr_stb), .mode(mode), .psc(psc),
    .per_act(per_act), .per_sh(per_sh), .cnt(cnt_o), .dn(dn), .tick(tick),
    .at_zero(at_zero), .at_prd(at_prd), .ld_end(ld_end), .ld_mid(ld_mid)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evpwm_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .cnt(cnt_o), .dn(dn), .mode(mode),
      .cmp(cmp_act[g]), .acts(act_tbl[g]), .at_zero(at_zero), .at_prd(at_prd),
      .men(men[g]), .mlvl(mlvl[g]), .pol(pol[g]), .pin(pwm_out[g]),
      .ev_cu(ev_cmpu[g]), .ev_cd(ev_cmpd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_zero <= 1'b0;
      ev_prd  <= 1'b0;
    end else begin
      ev_zero <= at_zero;
      ev_prd  <= at_prd;
    end
  end
endmodule

// File: rtl/evpwm_chk.sv
module evpwm_chk
  import evpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic           wr_en,
  input logic [4:0]     wr_addr,
  input logic [CW-1:0]  cnt_o,
  input logic           ev_zero,
  input logic           ev_prd,
  input logic [NCH-1:0] ev_cmpu,
  input logic [NCH-1:0] ev_cmpd,
  input logic [1:0]     mode,
  input logic [CW-1:0]  per_act
);
  logic clr_w;
  assign clr_w = wr_en && (wr_addr == 5'(A_CLR));

  assert_leg_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_cmpu & ev_cmpd) == '0);

  assert_zero_follows_count_R3: assert property (@(posedge clk) disable iff (rst)
    ev_zero |-> ($past(cnt_o) == '0));

  assert_prd_follows_count_R3: assert property (@(posedge clk) disable iff (rst)
    ev_prd |-> ($past(cnt_o) == $past(per_act)));

  assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr_w) |=> $stable(cnt_o));

  assert_stopped_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!ev_zero && !ev_prd && ev_cmpu == '0 && ev_cmpd == '0));

  assert_clear_start_R13: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> (cnt_o == (($past(mode) == MD_DOWN) ? $past(per_act) : '0)));
endmodule

bind evpwm_top evpwm_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
  .cnt_o(cnt_o), .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpu(ev_cmpu),
  .ev_cmpd(ev_cmpd), .mode(mode), .per_act(per_act)
);

// File: tb/tb_evpwm_top.sv
`timescale 1ns/1ps
module tb_evpwm_top;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [N-1:0] pwm_out, ev_cmpu, ev_cmpd;
  logic [15:0] cnt_o;
  logic        ev_zero, ev_prd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  evpwm_top dut (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .cnt_o(cnt_o), .ev_zero(ev_zero),
    .ev_prd(ev_prd), .ev_cmpu(ev_cmpu), .ev_cmpd(ev_cmpd)
  );

  // Reference model built from the requirements
  logic [11:0] m_psc, m_pc;
  logic [15:0] m_ps, m_pa, m_cnt;
  logic [15:0] m_cs [N];
  logic [15:0] m_ca [N];
  logic [7:0]  m_act [N];
  logic [1:0]  m_mode;
  logic        m_imm, m_mid, m_dn, m_ez, m_ep;
  logic [N-1:0] m_men, m_mlv, m_pol, m_wav, m_out, m_ecu, m_ecd;

  always @(posedge clk) begin : model
    logic tk, zh, ph, bnd, ld, hit, fl, w;
    logic [15:0] nc;
    logic nd;
    logic [1:0] pick;
    if (rst) begin
      m_psc <= 0; m_pc <= 0; m_ps <= 0; m_pa <= 0; m_cnt <= 0; m_mode <= 0;
      m_imm <= 0; m_mid <= 0; m_dn <= 0; m_ez <= 0; m_ep <= 0;
      m_men <= 0; m_mlv <= 0; m_pol <= 0; m_wav <= 0; m_out <= 0;
      m_ecu <= 0; m_ecd <= 0;
      for (int i = 0; i < N; i++) begin m_cs[i] <= 0; m_ca[i] <= 0; m_act[i] <= 0; end
    end else begin
      tk = run && (m_pa != 0) && (m_pc >= m_psc);
      zh = tk && (m_cnt == 0);
      ph = tk && (m_cnt == m_pa);
      nc = m_cnt; nd = m_dn; bnd = 0;
      if (tk) begin
        if (m_mode == 2'd1) begin
          bnd = (m_cnt == 0);
          nc = bnd ? m_ps : m_cnt - 16'd1;
        end else if (m_mode == 2'd2) begin
          bnd = (m_cnt == 0);
          if (m_cnt >= m_pa) begin nc = m_pa - 16'd1; nd = 1; end
          else if (m_cnt == 0) begin nc = 16'd1; nd = 0; end
          else nc = m_dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
        end else begin
          bnd = (m_cnt >= m_pa);
          nc = bnd ? 16'd0 : m_cnt + 16'd1;
        end
      end
      if (wr_en && wr_addr == 5'd3) begin
        nc = (m_mode == 2'd1) ? m_pa : 16'd0; nd = 0; m_pc <= 0;
      end else if (run && m_pa != 0) begin
        m_pc <= tk ? 12'd0 : m_pc + 12'd1;
      end
      m_cnt <= nc; m_dn <= nd;
      ld = bnd || (tk && m_mode == 2'd2 && m_mid && m_cnt >= m_pa) || (m_pa == 0);
      m_ez <= zh; m_ep <= ph;
      for (int i = 0; i < N; i++) begin
        hit = tk && (m_cnt == m_ca[i]);
        fl = (m_mode == 2'd1) || (m_mode == 2'd2 && m_dn);
        m_ecd[i] <= hit && fl;
        m_ecu[i] <= hit && !fl;
        pick = 0;
        if (hit && fl && m_act[i][7:6] != 0) pick = m_act[i][7:6];
        else if (hit && !fl && m_act[i][3:2] != 0) pick = m_act[i][3:2];
        else if (ph && m_act[i][5:4] != 0) pick = m_act[i][5:4];
        else if (zh && m_act[i][1:0] != 0) pick = m_act[i][1:0];
        w = (pick == 1) ? 1'b0 : (pick == 2) ? 1'b1 : (pick == 3) ? ~m_wav[i] : m_wav[i];
        m_wav[i] <= w;
        m_out[i] <= (m_men[i] ? m_mlv[i] : w) ^ m_pol[i];
        if (wr_en && wr_addr == 5'(8 + i) && m_imm) m_ca[i] <= wr_data;
        else if (ld) m_ca[i] <= m_cs[i];
        if (wr_en && wr_addr == 5'(8 + i)) m_cs[i] <= wr_data;
        if (wr_en && wr_addr == 5'(16 + i)) m_act[i] <= wr_data[7:0];
      end
      if (wr_en && wr_addr == 5'd1 && m_imm) m_pa <= wr_data;
      else if (ld) m_pa <= m_ps;
      if (wr_en) begin
        case (wr_addr)
          5'd0: m_psc <= wr_data[11:0];
          5'd1: m_ps <= wr_data;
          5'd2: begin m_mode <= wr_data[1:0]; m_imm <= wr_data[2]; m_mid <= wr_data[3]; end
          5'd4: m_men <= wr_data[N-1:0];
          5'd5: m_mlv <= wr_data[N-1:0];
          5'd6: m_pol <= wr_data[N-1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk();
    n_chk++;
    if (pwm_out !== m_out || cnt_o !== m_cnt || ev_zero !== m_ez || ev_prd !== m_ep ||
        ev_cmpu !== m_ecu || ev_cmpd !== m_ecd) begin
      n_bad++;
      $display("FAIL %s: out=%h/%h cnt=%0d/%0d z=%b/%b p=%b/%b cu=%h/%h cd=%h/%h",
               tag, pwm_out, m_out, cnt_o, m_cnt, ev_zero, m_ez, ev_prd, m_ep,
               ev_cmpu, m_ecu, ev_cmpd, m_ecd);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk();
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    chk();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state against fixed constants
    n_chk++;
    if (pwm_out !== 0 || cnt_o !== 0 || ev_zero || ev_prd || ev_cmpu !== 0 || ev_cmpd !== 0) begin
      n_bad++;
      $display("FAIL R1: out=%h cnt=%0d ev=%b%b%h%h expected all zero",
               pwm_out, cnt_o, ev_zero, ev_prd, ev_cmpu, ev_cmpd);
    end
    chk();

    tag = "R6"; run = 1'b1; step(5);          // period 0: held
    tag = "R2"; wr(5'd0, 16'd2); wr(5'd1, 16'd5);
    wr(5'd8, 16'd2); wr(5'd16, 16'h06);       // ch0: zero->high, up-cmp->low
    step(40);
    tag = "R3"; wr(5'd0, 16'd0); step(30);
    tag = "R7"; wr(5'd1, 16'd8); wr(5'd9, 16'd3); wr(5'd17, 16'h0B); step(40);
    tag = "R8"; wr(5'd2, 16'h4); wr(5'd1, 16'd3); wr(5'd8, 16'd1); step(20);
    tag = "R4"; wr(5'd2, 16'h1); wr(5'd1, 16'd6); wr(5'd3, 16'd0);
    wr(5'd18, 16'h40 | 16'h02); wr(5'd10, 16'd2); step(40);
    tag = "R5"; wr(5'd2, 16'h2); wr(5'd3, 16'd0);
    wr(5'd19, 16'h44); wr(5'd11, 16'd3); step(50);
    tag = "R9"; wr(5'd2, 16'hA); wr(5'd1, 16'd4); step(6); wr(5'd11, 16'd1); step(40);
    tag = "R11"; wr(5'd2, 16'h2); wr(5'd8, 16'd0); wr(5'd16, 16'h4E);
    wr(5'd9, 16'd4); wr(5'd17, 16'h38); step(60);
    tag = "R12"; wr(5'd4, 16'h05); wr(5'd5, 16'h01); wr(5'd6, 16'h2A); step(30);
    wr(5'd4, 16'h00); step(20);
    tag = "R13"; step(3); wr(5'd3, 16'd0); step(10);
    wr(5'd2, 16'h1); wr(5'd3, 16'd0); step(10);
    tag = "R6"; run = 1'b0; step(10); wr(5'd3, 16'd0); step(5); run = 1'b1; step(10);
    tag = "R14"; wr(5'd2, 16'h0); wr(5'd0, 16'd1); step(30);

    tag = "R10";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom % 32);
      if (r < 4) begin
        int ch;
        ch = int'($urandom % N);
        case ($urandom % 9)
          0: wr(5'd0, 16'($urandom % 4));
          1: wr(5'd1, 16'(1 + $urandom % 20));
          2: wr(5'd2, 16'($urandom % 16));
          3: wr(5'd3, 16'd0);
          4: wr(5'd4, 16'($urandom % 64));
          5: wr(5'd5, 16'($urandom % 64));
          6: wr(5'd6, 16'($urandom % 64));
          7: wr(5'(8 + ch), 16'($urandom % 23));
          default: wr(5'(16 + ch), 16'($urandom % 256));
        endcase
      end else if (r == 4) begin
        run = ~run; step(1);
      end else begin
        step(1);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule